// File: doc/BRIEF.md
# Bank Address Translator with Nametable Mirroring

This block turns the contents of a cartridge mapper's register file into physical memory addresses. The CPU program window at 0x8000–0xFFFF is divided into four 8 KB slots. Two of them take a programmable bank, and two are tied to the last banks of the ROM. A control bit can exchange the first and third slots. The pattern table window at 0x0000–0x1FFF is divided into eight 1 KB slots, and each slot has its own bank selector. The block also produces the A10 line of the nametable RAM from the mirroring control.

A work RAM window at 0x6000–0x7FFF is gated by an enable bit. While the gate is closed, reads of that window must return the open-bus value, which the block presents alongside a select. An input selects the variant. The full variant honours the RAM gate and offers single-screen mirroring. The reduced variant keeps the RAM always open and offers only horizontal and vertical mirroring.

The whole path is combinational, so the registers feeding it and any interrupt logic sit outside the block.

Top module: `bank_xlat`

## Requirements
- R1: The program slot is cpu_addr[14:13]. With misc_ctl[1]=0, slot 0 uses prg_sel0 and slot 1 uses prg_sel1.
- R2: With misc_ctl[1]=0, slot 2 maps to the second-to-last bank (all ones except bit 0, 0xFE at the default width) and slot 3 maps to the last bank (all ones, 0xFF).
- R3: With misc_ctl[1]=1, slot 0 maps to the second-to-last bank and slot 2 maps to prg_sel0. Slots 1 and 3 are unaffected. The swap works the same in both variants.
- R4: prg_rom_addr is the selected bank concatenated above cpu_addr[12:0].
- R5: chr_addr is the bank field of chr_sel for slot ppu_addr[12:10] (slot k at bits k*CHR_BANK_W upward), concatenated above ppu_addr[9:0].
- R6: When single-screen is not selected, nt_a10 equals ppu_addr[11] if mirror_ctl[0]=1 (horizontal) and ppu_addr[10] if mirror_ctl[0]=0 (vertical). In the reduced variant (full_mode=0), mirror_ctl[1] is ignored.
- R7: With full_mode=1 and mirror_ctl[1]=1, nt_a10 is held at mirror_ctl[0] for every PPU address.
- R8: wram_en is 1 only when cpu_addr lies in 0x6000–0x7FFF and either misc_ctl[0]=1 or full_mode=0.
- R9: wram_addr is cpu_addr minus 0x6000, kept to its low WRAM_ADDR_W bits.
- R10: When cpu_addr lies in 0x6000–0x7FFF and the RAM is gated off, open_bus_sel is 1 and open_bus_data is cpu_addr[15:8]. Otherwise open_bus_sel is 0. open_bus_sel and wram_en are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 16 | CPU bus address |
| ppu_addr | input | 13 | PPU bus address, low 13 bits |
| prg_sel0 | input | PRG_BANK_W | Bank for the swappable first/third slot |
| prg_sel1 | input | PRG_BANK_W | Bank for the second slot |
| chr_sel | input | 8*CHR_BANK_W | Eight packed 1 KB pattern bank fields |
| mirror_ctl | input | 2 | Bit 1 selects single-screen, bit 0 selects the screen or the H/V choice |
| misc_ctl | input | 2 | Bit 1 swaps the slots, bit 0 opens the work RAM |
| full_mode | input | 1 | 1 selects the full variant, 0 the reduced variant |
| prg_rom_addr | output | PRG_BANK_W+13 | Program ROM byte address |
| chr_addr | output | CHR_BANK_W+10 | Pattern memory byte address |
| wram_en | output | 1 | Work RAM access enabled |
| wram_addr | output | WRAM_ADDR_W | Work RAM byte address |
| open_bus_sel | output | 1 | A read of the window must return open_bus_data |
| open_bus_data | output | 8 | Open-bus value for a gated RAM read |
| nt_a10 | output | 1 | Nametable RAM A10 |

## Verification
Assertions placed beside the logic check several properties on every evaluation. Odd slots never depend on the swap bit. With the swap active, slot 0 always lands on the fixed bank. Single-screen mode pins nt_a10 to its control bit. The RAM enable and the open-bus select cover exactly the 0x6000–0x7FFF window and never overlap. The concrete bank numbers, the per-slot pattern bank routing, the horizontal and vertical address selection, the RAM offset and the open-bus byte are shown only by the bench's scenarios, which compare against values worked out from the requirements.

// File: rtl/bank_xlat_pkg.sv
package bank_xlat_pkg;

   typedef enum logic [1:0] {
      NT_VERT      = 2'd0,
      NT_HORZ      = 2'd1,
      NT_SCREEN_LO = 2'd2,
      NT_SCREEN_HI = 2'd3
   } nt_mode_t;

   // Upper three CPU address bits of the work RAM window (0x6000-0x7FFF)
   localparam logic [2:0] WRAM_WINDOW = 3'b011;

   function automatic nt_mode_t nt_decode(input logic full, input logic [1:0] ctl);
      if (full && ctl[1])
         return ctl[0] ? NT_SCREEN_HI : NT_SCREEN_LO;
      return ctl[0] ? NT_HORZ : NT_VERT;
   endfunction

endpackage

// File: rtl/bank_prg_slot.sv
module bank_prg_slot #(
   parameter int PRG_BANK_W = 8
) (
   input  logic [1:0]            slot,
   input  logic [PRG_BANK_W-1:0] sel0,
   input  logic [PRG_BANK_W-1:0] sel1,
   input  logic                  swap_en,
   output logic [PRG_BANK_W-1:0] bank
);
   localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;
   localparam logic [PRG_BANK_W-1:0] PENULT    = LAST_BANK - 1'b1;

   logic [1:0] eff_slot;

   always_comb begin
      eff_slot = slot;
      // even slots trade places when the swap bit is set
      if (swap_en && !slot[0])
         eff_slot[1] = ~slot[1];
      if (eff_slot[1])
         bank = {{(PRG_BANK_W-1){1'b1}}, eff_slot[0]};
      else
         bank = eff_slot[0] ? sel1 : sel0;
   end

   always_comb begin
      if (slot[0])
         AST_ODD_SLOT_FIXED: assert (bank == (slot[1] ? LAST_BANK : sel1)); // R3
      if (swap_en && slot == 2'd0)
         AST_SWAP_TO_FIXED: assert (bank == PENULT); // R3
      if (!swap_en && slot == 2'd0)
         AST_FIRST_DIRECT: assert (bank == sel0); // R1
   end
endmodule

// File: rtl/bank_chr_slot.sv
module bank_chr_slot #(
   parameter int CHR_BANK_W = 9,
   parameter int CHR_SLOTS  = 8
) (
   input  logic [$clog2(CHR_SLOTS)+9:0]      ppu_addr,
   input  logic [CHR_SLOTS*CHR_BANK_W-1:0]   chr_sel,
   output logic [CHR_BANK_W+9:0]             chr_addr
);
   localparam int SLOT_BITS = $clog2(CHR_SLOTS);

   logic [CHR_BANK_W-1:0] slot_bank [CHR_SLOTS];

   for (genvar g = 0; g < CHR_SLOTS; g++) begin : g_slot
      assign slot_bank[g] = chr_sel[g*CHR_BANK_W +: CHR_BANK_W];
   end

   assign chr_addr = {slot_bank[ppu_addr[SLOT_BITS+9:10]], ppu_addr[9:0]};
endmodule

// File: rtl/bank_nt_mirror.sv
module bank_nt_mirror
   import bank_xlat_pkg::*;
(
   input  logic       full_mode,
   input  logic [1:0] ctl,
   input  logic       ppu_a11,
   input  logic       ppu_a10,
   output logic       nt_a10
);
   nt_mode_t mode;

   always_comb begin
      mode = nt_decode(full_mode, ctl);
      unique case (mode)
         NT_HORZ:      nt_a10 = ppu_a11;
         NT_VERT:      nt_a10 = ppu_a10;
         NT_SCREEN_LO: nt_a10 = 1'b0;
         NT_SCREEN_HI: nt_a10 = 1'b1;
         default:      nt_a10 = ppu_a10;
      endcase
   end

   always_comb begin
      if (full_mode && ctl[1])
         AST_ONE_SCREEN_CONST: assert (nt_a10 == ctl[0]); // R7
   end
endmodule

// File: rtl/bank_wram_gate.sv
module bank_wram_gate
   import bank_xlat_pkg::*;
#(
   parameter int WRAM_ADDR_W = 13
) (
   input  logic [15:0]            cpu_addr,
   input  logic                   full_mode,
   input  logic                   ram_on,
   output logic                   wram_en,
   output logic [WRAM_ADDR_W-1:0] wram_addr,
   output logic                   open_bus_sel,
   output logic [7:0]             open_bus_data
);
   logic in_window;
   logic allowed;

   assign in_window     = (cpu_addr[15:13] == WRAM_WINDOW);
   assign allowed       = ram_on || !full_mode;
   assign wram_en       = in_window && allowed;
   assign open_bus_sel  = in_window && !allowed;
   assign open_bus_data = open_bus_sel ? cpu_addr[15:8] : 8'h00;
   // the window base has zero low 13 bits, so the offset is a plain slice
   assign wram_addr     = cpu_addr[WRAM_ADDR_W-1:0];

   always_comb begin
      AST_GATE_EXCLUSIVE: assert (!(wram_en && open_bus_sel)); // R10
      AST_GATE_WINDOW: assert ((wram_en || open_bus_sel) ==
                               (cpu_addr >= 16'h6000 && cpu_addr <= 16'h7FFF)); // R8
   end
endmodule

// File: rtl/bank_xlat.sv
module bank_xlat #(
   parameter int PRG_BANK_W  = 8,
   parameter int CHR_BANK_W  = 9,
   parameter int WRAM_ADDR_W = 13
) (
   input  logic [15:0]              cpu_addr,
   input  logic [12:0]              ppu_addr,
   input  logic [PRG_BANK_W-1:0]    prg_sel0,
   input  logic [PRG_BANK_W-1:0]    prg_sel1,
   input  logic [8*CHR_BANK_W-1:0]  chr_sel,
   input  logic [1:0]               mirror_ctl,
   input  logic [1:0]               misc_ctl,
   input  logic                     full_mode,
   output logic [PRG_BANK_W+12:0]   prg_rom_addr,
   output logic [CHR_BANK_W+9:0]    chr_addr,
   output logic                     wram_en,
   output logic [WRAM_ADDR_W-1:0]   wram_addr,
   output logic                     open_bus_sel,
   output logic [7:0]               open_bus_data,
   output logic                     nt_a10
);
   localparam int CHR_SLOTS = 8;

   if (PRG_BANK_W < 2) begin : g_bad_prg
      $error("PRG_BANK_W must be at least 2");
   end
   if (CHR_BANK_W < 1) begin : g_bad_chr
      $error("CHR_BANK_W must be at least 1");
   end
   if (WRAM_ADDR_W < 1 || WRAM_ADDR_W > 13) begin : g_bad_wram
      $error("WRAM_ADDR_W must lie in 1..13");
   end

   logic [PRG_BANK_W-1:0] prg_bank;

   bank_prg_slot #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
      .slot    (cpu_addr[14:13]),
      .sel0    (prg_sel0),
      .sel1    (prg_sel1),
      .swap_en (misc_ctl[1]),
      .bank    (prg_bank)
   );

   assign prg_rom_addr = {prg_bank, cpu_addr[12:0]};

   bank_chr_slot #(.CHR_BANK_W(CHR_BANK_W), .CHR_SLOTS(CHR_SLOTS)) u_chr (
      .ppu_addr (ppu_addr),
      .chr_sel  (chr_sel),
      .chr_addr (chr_addr)
   );

   bank_nt_mirror u_nt (
      .full_mode (full_mode),
      .ctl       (mirror_ctl),
      .ppu_a11   (ppu_addr[11]),
      .ppu_a10   (ppu_addr[10]),
      .nt_a10    (nt_a10)
   );

   bank_wram_gate #(.WRAM_ADDR_W(WRAM_ADDR_W)) u_wram (
      .cpu_addr      (cpu_addr),
      .full_mode     (full_mode),
      .ram_on        (misc_ctl[0]),
      .wram_en       (wram_en),
      .wram_addr     (wram_addr),
      .open_bus_sel  (open_bus_sel),
      .open_bus_data (open_bus_data)
   );
endmodule

// File: tb/tb_bank_xlat.sv
module tb_bank_xlat;
   localparam int PB = 8;
   localparam int CB = 9;
   localparam int WA = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [15:0]      cpu_addr;
   logic [12:0]      ppu_addr;
   logic [PB-1:0]    prg_sel0, prg_sel1;
   logic [8*CB-1:0]  chr_sel;
   logic [1:0]       mirror_ctl, misc_ctl;
   logic             full_mode;
   logic [PB+12:0]   prg_rom_addr;
   logic [CB+9:0]    chr_addr;
   logic             wram_en;
   logic [WA-1:0]    wram_addr;
   logic             open_bus_sel;
   logic [7:0]       open_bus_data;
   logic             nt_a10;

   bank_xlat #(.PRG_BANK_W(PB), .CHR_BANK_W(CB), .WRAM_ADDR_W(WA)) dut (
      .cpu_addr(cpu_addr), .ppu_addr(ppu_addr), .prg_sel0(prg_sel0),
      .prg_sel1(prg_sel1), .chr_sel(chr_sel), .mirror_ctl(mirror_ctl),
      .misc_ctl(misc_ctl), .full_mode(full_mode), .prg_rom_addr(prg_rom_addr),
      .chr_addr(chr_addr), .wram_en(wram_en), .wram_addr(wram_addr),
      .open_bus_sel(open_bus_sel), .open_bus_data(open_bus_data), .nt_a10(nt_a10)
   );

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // {cpu_addr, swap bit, full_mode, expected bank}; prg_sel0=0x15, prg_sel1=0x2A
   localparam logic [25:0] PRG_VEC [12] = '{
      {16'h8000, 1'b0, 1'b1, 8'h15},
      {16'hA000, 1'b0, 1'b1, 8'h2A},
      {16'hC000, 1'b0, 1'b1, 8'hFE},
      {16'hE000, 1'b0, 1'b1, 8'hFF},
      {16'h8000, 1'b1, 1'b1, 8'hFE},
      {16'hC000, 1'b1, 1'b1, 8'h15},
      {16'hA123, 1'b1, 1'b1, 8'h2A},
      {16'hFFFF, 1'b1, 1'b1, 8'hFF},
      {16'h9ABC, 1'b0, 1'b0, 8'h15},
      {16'hD000, 1'b1, 1'b0, 8'h15},
      {16'hBFFF, 1'b1, 1'b0, 8'h2A},
      {16'hC001, 1'b0, 1'b0, 8'hFE}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      cpu_addr = '0; ppu_addr = '0; prg_sel0 = '0; prg_sel1 = '0;
      chr_sel = '0; mirror_ctl = '0; misc_ctl = '0; full_mode = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      settle();
      // reset-state inputs: everything zero
      chk("R1 reset bank", 32'(prg_rom_addr), 32'h0);
      chk("R8 reset wram_en", 32'(wram_en), 32'h0);
      chk("R10 reset open_bus_sel", 32'(open_bus_sel), 32'h0);
      chk("R6 reset nt_a10", 32'(nt_a10), 32'h0);

      // program slot table: R1 R2 R3 R4
      prg_sel0 = 8'h15;
      prg_sel1 = 8'h2A;
      for (int i = 0; i < 12; i++) begin
         logic [7:0] e;
         logic       sw;
         {cpu_addr, sw, full_mode, e} = PRG_VEC[i];
         misc_ctl = {sw, 1'b0};
         settle();
         chk($sformatf("R1 R2 R3 R4 vec%0d", i), 32'(prg_rom_addr), 32'({e, cpu_addr[12:0]}));
      end

      // pattern slots R5
      for (int k = 0; k < 8; k++)
         chr_sel[k*CB +: CB] = 9'((k * 61 + 5) & 511);
      for (int k = 0; k < 8; k++) begin
         ppu_addr = 13'(k * 1024 + 'h155);
         settle();
         chk($sformatf("R5 slot%0d", k), 32'(chr_addr), 32'({9'((k * 61 + 5) & 511), 10'h155}));
      end

      // mirroring R6 / R7
      full_mode = 1'b0; mirror_ctl = 2'b01;
      ppu_addr = 13'h0800; settle(); chk("R6 horz a11=1", 32'(nt_a10), 32'h1);
      ppu_addr = 13'h0400; settle(); chk("R6 horz a10=1", 32'(nt_a10), 32'h0);
      mirror_ctl = 2'b11;
      ppu_addr = 13'h0400; settle(); chk("R6 reduced ignores bit1", 32'(nt_a10), 32'h0);
      ppu_addr = 13'h0800; settle(); chk("R6 reduced ignores bit1 b", 32'(nt_a10), 32'h1);
      mirror_ctl = 2'b00;
      ppu_addr = 13'h0400; settle(); chk("R6 vert a10=1", 32'(nt_a10), 32'h1);
      ppu_addr = 13'h0800; settle(); chk("R6 vert a11=1", 32'(nt_a10), 32'h0);
      full_mode = 1'b1;
      ppu_addr = 13'h0400; settle(); chk("R6 full vert", 32'(nt_a10), 32'h1);
      mirror_ctl = 2'b11;
      ppu_addr = 13'h0000; settle(); chk("R7 screen hi", 32'(nt_a10), 32'h1);
      ppu_addr = 13'h0C00; settle(); chk("R7 screen hi b", 32'(nt_a10), 32'h1);
      mirror_ctl = 2'b10;
      ppu_addr = 13'h0C00; settle(); chk("R7 screen lo", 32'(nt_a10), 32'h0);

      // work RAM gate R8 R9 R10
      misc_ctl = 2'b01; cpu_addr = 16'h6123; settle();
      chk("R8 open en", 32'(wram_en), 32'h1);
      chk("R9 offset", 32'(wram_addr), 32'h0123);
      chk("R10 no open bus", 32'(open_bus_sel), 32'h0);
      misc_ctl = 2'b00; settle();
      chk("R8 gated en", 32'(wram_en), 32'h0);
      chk("R10 gated sel", 32'(open_bus_sel), 32'h1);
      chk("R10 gated data", 32'(open_bus_data), 32'h61);
      cpu_addr = 16'h7FFF; settle();
      chk("R10 gated data top", 32'(open_bus_data), 32'h7F);
      full_mode = 1'b0; cpu_addr = 16'h7ABC; settle();
      chk("R8 reduced always on", 32'(wram_en), 32'h1);
      chk("R9 offset high", 32'(wram_addr), 32'h1ABC);
      chk("R10 reduced no open bus", 32'(open_bus_sel), 32'h0);
      full_mode = 1'b1; misc_ctl = 2'b01; cpu_addr = 16'h5FFF; settle();
      chk("R8 below window", 32'({wram_en, open_bus_sel}), 32'h0);
      cpu_addr = 16'h8000; settle();
      chk("R8 above window", 32'({wram_en, open_bus_sel}), 32'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule